// File: doc/BRIEF.md
# Bus-to-Device Four-Phase Handshake Sequencer

This block sits between a bus master and a local peripheral and runs the four-phase handshakes that move one read or one write across the boundary. On the bus side it receives a read strobe and a write strobe and returns a data acknowledge. On the device side it raises a request and waits for the device's acknowledge. A further output opens the transceiver that joins the bus data lines to the device data lines.

The two transfer kinds use the transceiver in opposite ways. A read asks the device first and opens the transceiver only once the device has answered, so the data can flow onto the bus. A write opens the transceiver first, then asks the device, and closes the transceiver as soon as the device answers, before the bus is acknowledged. Every transfer ends with all signals back at zero. On the way back the bus-side and device-side signals drop together wherever the ordering allows.

The design is clocked. Every input passes through a synchronizer chain and every output comes from a flop. A single internal hold bit records that a read is in progress. With it the controller can tell the start of a read apart from its release, although the visible signal levels are the same in both. A sticky error flag records strobe misuse.

Top module: `hs_bridge_ctrl`

## Requirements
- R1: While reset is asserted and on the first clock after it is released, xcvr_en_o, bus_ack_o, dev_req_o and proto_err_o are all 0.
- R2: In a read (rd_req_i=1), dev_req_o rises while xcvr_en_o is 0. xcvr_en_o rises only after dev_ack_i has been seen high. bus_ack_o is 1 with xcvr_en_o at 1.
- R3: When a read strobe is withdrawn, xcvr_en_o falls first. dev_req_o and bus_ack_o then fall on the same clock edge.
- R4: In a write (wr_req_i=1), xcvr_en_o is 1 when dev_req_o rises. After dev_ack_i is seen high, xcvr_en_o falls before bus_ack_o rises, so xcvr_en_o is 0 while bus_ack_o is 1.
- R5: When a write strobe is withdrawn, dev_req_o and bus_ack_o fall on the same clock edge, with xcvr_en_o already at 0.
- R6: dev_req_o does not rise while dev_ack_i is still high from an earlier transfer. It rises after dev_ack_i returns low.
- R7: proto_err_o goes to 1 when both strobes are high at the same time. It then stays at 1 after both strobes are low, until reset.
- R8: proto_err_o goes to 1 when a strobe falls while bus_ack_o is still 0.
- R9: After a read has released, with the read strobe low, dev_ack_i held high does not reopen the transceiver: xcvr_en_o and dev_req_o stay 0.
- R10: With the default two-stage synchronizer, a write strobe that is applied between clock edges raises xcvr_en_o on the third rising edge that follows, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | Bus read strobe, asynchronous |
| wr_req_i | input | 1 | Bus write strobe, asynchronous |
| dev_ack_i | input | 1 | Device acknowledge, asynchronous |
| xcvr_en_o | output | 1 | Opens the bus-to-device data transceiver |
| bus_ack_o | output | 1 | Data acknowledge returned to the bus |
| dev_req_o | output | 1 | Request to the device |
| proto_err_o | output | 1 | Sticky strobe-misuse flag |

## Verification
The properties assume a well-behaved four-phase device. It raises its acknowledge only while the request is high, and it drops the acknowledge only after the request has fallen. Checks on transfer ordering are gated off once the error flag is set. The bench drives the device acknowledge with this discipline in every ordinary transfer, and it holds each strobe until the bus acknowledge has risen. The stale-acknowledge scenario and the misuse scenarios break these rules on purpose. The ordering properties do not depend on them, and the bench issues a reset after each one.

// File: rtl/hs_bridge_ctrl.sv
module hs_bridge_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_req_i,
  input  logic wr_req_i,
  input  logic dev_ack_i,
  output logic xcvr_en_o,
  output logic bus_ack_o,
  output logic dev_req_o,
  output logic proto_err_o
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] rd_sync, wr_sync, ack_sync;
  logic rd_s, wr_s, ack_s;
  logic rd_q, wr_q;
  logic rd_hold;
  logic rd_hold_n, xcvr_n, req_n, back_n, err_n;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rd_sync  <= '0;
          wr_sync  <= '0;
          ack_sync <= '0;
        end else begin
          rd_sync  <= {rd_sync[LAST-1:0], rd_req_i};
          wr_sync  <= {wr_sync[LAST-1:0], wr_req_i};
          ack_sync <= {ack_sync[LAST-1:0], dev_ack_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rd_sync  <= '0;
          wr_sync  <= '0;
          ack_sync <= '0;
        end else begin
          rd_sync  <= rd_req_i;
          wr_sync  <= wr_req_i;
          ack_sync <= dev_ack_i;
        end
      end
    end
  endgenerate

  assign rd_s  = rd_sync[LAST];
  assign wr_s  = wr_sync[LAST];
  assign ack_s = ack_sync[LAST];

  assign rd_hold_n = rd_s & (rd_hold | ~ack_s);
  assign xcvr_n    = (ack_s & rd_hold) | (wr_s & ~ack_s);
  assign req_n     = rd_hold | xcvr_en_o | (wr_s & dev_req_o);
  assign back_n    = (xcvr_en_o & ~wr_s) | (wr_s & ack_s & dev_req_o & ~xcvr_en_o);
  assign err_n     = proto_err_o | (rd_s & wr_s)
                   | (rd_q & ~rd_s & ~bus_ack_o)
                   | (wr_q & ~wr_s & ~bus_ack_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q        <= 1'b0;
      wr_q        <= 1'b0;
      rd_hold     <= 1'b0;
      xcvr_en_o   <= 1'b0;
      dev_req_o   <= 1'b0;
      bus_ack_o   <= 1'b0;
      proto_err_o <= 1'b0;
    end else begin
      rd_q        <= rd_s;
      wr_q        <= wr_s;
      rd_hold     <= rd_hold_n;
      xcvr_en_o   <= xcvr_n;
      dev_req_o   <= req_n;
      bus_ack_o   <= back_n;
      proto_err_o <= err_n;
    end
  end

endmodule

// File: rtl/hs_bridge_ctrl_chk.sv
module hs_bridge_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_s,
  input logic ack_s,
  input logic xcvr_en_o,
  input logic bus_ack_o,
  input logic dev_req_o,
  input logic proto_err_o
);

  // R2
  read_open_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(xcvr_en_o) && dev_req_o && !proto_err_o) |-> $past(ack_s));

  // R3
  release_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dev_req_o) && !proto_err_o) |-> !bus_ack_o);

  // R4
  write_closed_at_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_ack_o) && wr_s && !proto_err_o) |-> !xcvr_en_o);

  // R6
  no_req_on_stale_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_req_o) |-> !ack_s);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(proto_err_o) |-> proto_err_o);

  // R9
  no_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xcvr_en_o) |-> !$past(bus_ack_o));

endmodule

bind hs_bridge_ctrl hs_bridge_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_s(wr_s), .ack_s(ack_s),
  .xcvr_en_o(xcvr_en_o), .bus_ack_o(bus_ack_o),
  .dev_req_o(dev_req_o), .proto_err_o(proto_err_o)
);

// File: tb/hs_bridge_ctrl_tb_top.sv
module hs_bridge_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd = 1'b0, wr = 1'b0, ack = 1'b0;
  logic xcvr, back, req, err;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hs_bridge_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .rd_req_i(rd), .wr_req_i(wr), .dev_ack_i(ack),
    .xcvr_en_o(xcvr), .bus_ack_o(back), .dev_req_o(req), .proto_err_o(err)
  );

  // {is_write, xcvr at req rise, xcvr at bus ack rise, ack delay[3:0]}
  localparam logic [6:0] VEC [6] = '{
    7'b0_0_1_0001, 7'b1_1_0_0001, 7'b0_0_1_0101,
    7'b1_1_0_0110, 7'b1_1_0_0000, 7'b0_0_1_1001
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic sel(input int s);
    case (s)
      0: return xcvr;
      1: return back;
      2: return req;
      default: return err;
    endcase
  endfunction

  task automatic wait_for(input int s, input logic v, input string tag);
    bit hit = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sel(s) == v) begin hit = 1'b1; break; end
    end
    chk(hit, tag, int'(sel(s)), int'(v));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rd = 1'b0; wr = 1'b0; ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    // R1
    repeat (2) @(negedge clk);
    chk({xcvr, back, req, err} == 4'b0, "R1 in reset", {xcvr, back, req, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({xcvr, back, req, err} == 4'b0, "R1 after reset", {xcvr, back, req, err}, 0);

    foreach (VEC[k]) begin
      logic w;
      w = VEC[k][6];
      if (w) wr = 1'b1; else rd = 1'b1;
      wait_for(2, 1'b1, w ? "R4 req rise" : "R2 req rise");
      chk(xcvr == VEC[k][5], w ? "R4 xcvr at req" : "R2 xcvr at req", xcvr, VEC[k][5]);
      repeat (int'(VEC[k][3:0])) @(negedge clk);
      if (!w) chk(xcvr == 1'b0, "R2 xcvr before ack", xcvr, 0);
      ack = 1'b1;
      wait_for(1, 1'b1, w ? "R4 bus ack" : "R2 bus ack");
      chk(xcvr == VEC[k][4], w ? "R4 xcvr at bus ack" : "R2 xcvr at bus ack", xcvr, VEC[k][4]);
      if (w) wr = 1'b0; else rd = 1'b0;
      wait_for(2, 1'b0, w ? "R5 req fall" : "R3 req fall");
      chk(back == 1'b0, w ? "R5 bus ack with req" : "R3 bus ack with req", back, 0);
      chk(xcvr == 1'b0, w ? "R5 xcvr closed" : "R3 xcvr closed", xcvr, 0);
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        chk(!xcvr && !req, "R9 no reopen", {xcvr, req}, 0);
      end
      ack = 1'b0;
      repeat (4) @(negedge clk);
      chk({xcvr, back, req, err} == 4'b0, "R3 idle after transfer", {xcvr, back, req, err}, 0);
    end

    // R10: latency of the write path through the synchronizer
    @(negedge clk);
    wr = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk(xcvr == 1'b0, "R10 not before third edge", xcvr, 0);
    @(negedge clk);
    chk(xcvr == 1'b1, "R10 on third edge", xcvr, 1);
    wait_for(2, 1'b1, "R10 req");
    ack = 1'b1;
    wait_for(1, 1'b1, "R10 bus ack");
    wr = 1'b0;
    wait_for(2, 1'b0, "R10 req fall");
    ack = 1'b0;
    repeat (4) @(negedge clk);

    // R6: stale acknowledge blocks a new request
    do_reset();
    ack = 1'b1;
    rd = 1'b1;
    repeat (10) @(negedge clk);
    chk(req == 1'b0, "R6 req held on stale ack", req, 0);
    chk(xcvr == 1'b0, "R6 xcvr held on stale ack", xcvr, 0);
    ack = 1'b0;
    wait_for(2, 1'b1, "R6 req after ack low");
    ack = 1'b1;
    wait_for(1, 1'b1, "R6 bus ack");
    rd = 1'b0;
    wait_for(2, 1'b0, "R6 req fall");
    ack = 1'b0;
    repeat (4) @(negedge clk);
    chk(err == 1'b0, "R6 no error", err, 0);

    // R7: both strobes at once, sticky
    do_reset();
    rd = 1'b1; wr = 1'b1;
    repeat (5) @(negedge clk);
    chk(err == 1'b1, "R7 both strobes", err, 1);
    rd = 1'b0; wr = 1'b0;
    repeat (8) @(negedge clk);
    chk(err == 1'b1, "R7 sticky", err, 1);
    do_reset();
    chk(err == 1'b0, "R7 cleared by reset", err, 0);

    // R8: strobe withdrawn before bus acknowledge
    rd = 1'b1;
    wait_for(2, 1'b1, "R8 req");
    rd = 1'b0;
    repeat (5) @(negedge clk);
    chk(err == 1'b1, "R8 early strobe fall", err, 1);
    do_reset();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule